// File: doc/BRIEF.md
# SMBus Backlight Register Slave

This block is the serial control port of an LED backlight controller. It samples the SMBus clock and data lines with a fast system clock and answers the 7-bit address 0x2C. It drives the data line only through an open-drain enable. Two transfer types are supported: single-byte writes and single-byte reads. A read uses a repeated START after the command code.

Four byte-wide registers sit behind the port:
- a brightness level;
- a control byte that holds backlight enable, the brightness source select and the PWM interpretation;
- a live status byte, built each time from fault inputs and a count of disabled LED strings;
- a fixed identification byte.

The brightness and control fields leave the block as plain outputs to the dimming logic.

Writes to the brightness register take effect only while the serial bus owns brightness. Command codes above 3 are acknowledged but do nothing. A START or STOP in the middle of a transfer drops whatever was partly received.

Top module: `bl_smbus_regs`

## Requirements
- R1: The slave acknowledges an address byte of 0x58 (write) or 0x59 (read), which is address 0x2C plus the R/W bit. For any other address it returns no acknowledge and leaves SDA released until the next START.
- R2: A write transfer has three bytes: address with W, then command code, then data. The slave acknowledges each byte. Command 0x00 loads the brightness register, and the new value appears on `brightness` one cycle after the data byte is taken.
- R3: Brightness resets to 0xFF and can always be read at command 0x00. A write to it is ignored while control bit1 (source select) is 1.
- R4: Control register 0x01 resets to 0x00. Bit0 drives `bl_on`, bit1 drives `pwm_sel` and bit2 drives `pwm_md`. Bits 7:3 read as 0 and ignore writes.
- R5: Status register 0x02 is read-only and is built live from the inputs:
  - bit1 = thermal fault;
  - bit2 = overcurrent;
  - bit3 = `bl_lit`;
  - bit4 = at least one string disabled;
  - bit5 = at least two strings disabled;
  - bit0 = OR of bits 1, 2, 4 and 5;
  - bits 7:6 = 0.
- R6: Register 0x03 is read-only and returns 0xB0: bit7 = 1 for an LED panel, bits 6:3 = maker code 6, bits 2:0 = revision 0.
- R7: Writing 0 to control bit0 drops `bl_on` on the cycle after the data byte is taken. Writing 1 raises it on that same cycle, which is well inside the allowed 10 ms.
- R8: Writes to command codes above 0x03 are acknowledged and discarded. Reads from those codes return 0x00.
- R9: A STOP, or a START arriving mid-transfer, aborts the transfer. Nothing is written and SDA is released.
- R10: The slave only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| flt_thermal | input | 1 | Thermal shutdown fault |
| flt_ocp | input | 1 | Input overcurrent fault |
| bl_lit | input | 1 | Backlight currently lit |
| str_off | input | NSTR | One bit per LED string, 1 = disabled |
| brightness | output | 8 | Brightness register value |
| bl_on | output | 1 | Backlight enable (control bit0) |
| pwm_sel | output | 1 | 1 = PWM input drives brightness (control bit1) |
| pwm_md | output | 1 | 1 = absolute, 0 = percent change (control bit2) |

## Verification
A wrong bit counter or a wrong state in the byte engine shows up as a missing or misplaced acknowledge within one SCL period of the fault. It can also appear as a read byte shifted by one position on the following read. A wrong register update is visible on the field outputs one system clock after the data byte's eighth falling SCL edge, and again on the next readback. A bad status calculation appears only in the byte a read returns, so the status inputs are swept through patterns that separate the zero-, one- and many-string cases.

// File: rtl/bl_smb_pkg.sv
package bl_smb_pkg;

  localparam logic [6:0] SLV_ADDR = 7'h2C;
  localparam logic [7:0] ID_BYTE  = 8'hB0;

  localparam logic [7:0] CMD_BRI  = 8'h00;
  localparam logic [7:0] CMD_CTL  = 8'h01;
  localparam logic [7:0] CMD_STAT = 8'h02;
  localparam logic [7:0] CMD_ID   = 8'h03;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_ACK,
    LK_TX,
    LK_MACK,
    LK_SKIP
  } lk_state_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_CMD,
    RX_DATA
  } rx_kind_t;

  function automatic logic addr_hit(input logic [7:0] b);
    return b[7:1] == SLV_ADDR;
  endfunction

  function automatic logic [7:0] status_byte(input logic thm, input logic ocp,
                                             input logic lit, input logic one_off,
                                             input logic two_off);
    logic any;
    any = thm | ocp | one_off | two_off;
    return {2'b00, two_off, one_off, lit, ocp, thm, any};
  endfunction

endpackage

// File: rtl/bl_smb_sync.sv
module bl_smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/bl_smb_link.sv
module bl_smb_link
  import bl_smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  lk_state_t  st;
  rx_kind_t   kind;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic [7:0] cmd;
  logic       reading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= LK_IDLE;
      kind    <= RX_ADDR;
      sh      <= '0;
      cnt     <= '0;
      cmd     <= '0;
      reading <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        st     <= LK_RX;
        kind   <= RX_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                RX_ADDR: begin
                  if (addr_hit(sh)) begin
                    sda_oe  <= 1'b1;
                    reading <= sh[0];
                    st      <= LK_ACK;
                  end else begin
                    st <= LK_SKIP;
                  end
                end
                RX_CMD: begin
                  sda_oe <= 1'b1;
                  cmd    <= sh;
                  st     <= LK_ACK;
                end
                default: begin
                  sda_oe  <= 1'b1;
                  wr_stb  <= 1'b1;
                  wr_data <= sh;
                  st      <= LK_ACK;
                end
              endcase
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == RX_ADDR && reading) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                case (kind)
                  RX_ADDR: begin kind <= RX_CMD;  st <= LK_RX; end
                  RX_CMD:  begin kind <= RX_DATA; st <= LK_RX; end
                  default: st <= LK_SKIP;
                endcase
              end
            end
          end
          LK_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= LK_MACK;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
              end
            end
          end
          LK_MACK: begin
            if (scl_fall) st <= LK_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = cmd;
  assign wr_addr = cmd;

endmodule

// File: rtl/bl_smb_regfile.sv
module bl_smb_regfile
  import bl_smb_pkg::*;
#(
  parameter int NSTR = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_addr,
  input  logic            flt_thermal,
  input  logic            flt_ocp,
  input  logic            bl_lit,
  input  logic [NSTR-1:0] str_off,
  output logic [7:0]      rd_data,
  output logic [7:0]      status_q,
  output logic            bri_wr_ok,
  output logic [7:0]      brightness,
  output logic            bl_on,
  output logic            pwm_sel,
  output logic            pwm_md
);

  localparam int CW = $clog2(NSTR + 1);

  logic [2:0]    ctl;
  logic [CW-1:0] off_cnt;

  always_comb begin
    off_cnt = '0;
    for (int i = 0; i < NSTR; i++) off_cnt = off_cnt + CW'(str_off[i]);
  end

  assign status_q  = status_byte(flt_thermal, flt_ocp, bl_lit,
                                 off_cnt != '0, off_cnt > CW'(1));
  assign bri_wr_ok = wr_stb && wr_addr == CMD_BRI && !ctl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brightness <= 8'hFF;
      ctl        <= '0;
    end else begin
      if (bri_wr_ok) brightness <= wr_data;
      if (wr_stb && wr_addr == CMD_CTL) ctl <= wr_data[2:0];
    end
  end

  always_comb begin
    case (rd_addr)
      CMD_BRI:  rd_data = brightness;
      CMD_CTL:  rd_data = {5'b00000, ctl};
      CMD_STAT: rd_data = status_q;
      CMD_ID:   rd_data = ID_BYTE;
      default:  rd_data = 8'h00;
    endcase
  end

  assign bl_on   = ctl[0];
  assign pwm_sel = ctl[1];
  assign pwm_md  = ctl[2];

endmodule

// File: rtl/bl_smbus_regs.sv
module bl_smbus_regs
  import bl_smb_pkg::*;
#(
  parameter int NSTR        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  input  logic            flt_thermal,
  input  logic            flt_ocp,
  input  logic            bl_lit,
  input  logic [NSTR-1:0] str_off,
  output logic [7:0]      brightness,
  output logic            bl_on,
  output logic            pwm_sel,
  output logic            pwm_md
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data, status_q;
  logic       wr_stb, bri_wr_ok;

  bl_smb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bl_smb_link i_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  bl_smb_regfile #(.NSTR(NSTR)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .flt_thermal(flt_thermal),
    .flt_ocp(flt_ocp), .bl_lit(bl_lit), .str_off(str_off),
    .rd_data(rd_data), .status_q(status_q), .bri_wr_ok(bri_wr_ok),
    .brightness(brightness), .bl_on(bl_on), .pwm_sel(pwm_sel), .pwm_md(pwm_md)
  );

endmodule

// File: rtl/bl_smb_chk.sv
module bl_smb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] brightness,
  input logic [7:0] status_q,
  input logic       flt_thermal,
  input logic       bl_on,
  input logic       pwm_sel
);

  AST_BRI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (brightness != $past(brightness)) |->
      ($past(wr_stb) && $past(wr_addr) == 8'h00 && !$past(pwm_sel))); // R3

  AST_BRI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'h00 && !pwm_sel) |=> brightness == $past(wr_data)); // R2

  AST_BLON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'h01 && !wr_data[0]) |=> !bl_on); // R7

  AST_HIGH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr > 8'h03) |=> ($stable(brightness) && $stable(bl_on))); // R8

  AST_THERMAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flt_thermal |-> (status_q[1] && status_q[0])); // R5

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe); // R9

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R10

endmodule

bind bl_smbus_regs bl_smb_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .brightness(brightness), .status_q(status_q),
  .flt_thermal(flt_thermal), .bl_on(bl_on), .pwm_sel(pwm_sel)
);

// File: tb/test_bl_smbus_regs.sv
module test_bl_smbus_regs;

  localparam int NSTR = 8;
  localparam int H    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic flt_thermal = 1'b0, flt_ocp = 1'b0, bl_lit = 1'b0;
  logic [NSTR-1:0] str_off = '0;
  logic [7:0] brightness;
  logic bl_on, pwm_sel, pwm_md;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int oe_high_scl = 0;
  logic oe_prev = 1'b0;
  logic oe_seen = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  bl_smbus_regs #(.NSTR(NSTR)) i_bl_smbus_regs (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .flt_thermal(flt_thermal), .flt_ocp(flt_ocp), .bl_lit(bl_lit),
    .str_off(str_off), .brightness(brightness), .bl_on(bl_on),
    .pwm_sel(pwm_sel), .pwm_md(pwm_md)
  );

  // R10 monitor: SDA pull-down must never begin while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) oe_high_scl++;
    if (sda_oe) oe_seen = 1'b1;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic m_bit_out(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic m_bit_in(output logic b);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H / 2);
    b = sda_bus; wt(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) m_bit_out(b[i]);
    m_bit_in(a);
    ack = !a;
  endtask

  task automatic m_recv(output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      m_bit_in(x);
      b[i] = x;
    end
    m_bit_out(1'b1);
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input logic [7:0] dat, output logic ok);
    logic a1, a2, a3;
    m_start;
    m_send(8'h58, a1);
    m_send(cmd, a2);
    m_send(dat, a3);
    m_stop;
    ok = a1 & a2 & a3;
  endtask

  task automatic rd_txn(input logic [7:0] cmd, output logic [7:0] dat, output logic ok);
    logic a1, a2, a3;
    m_start;
    m_send(8'h58, a1);
    m_send(cmd, a2);
    m_start;
    m_send(8'h59, a3);
    m_recv(dat);
    m_stop;
    ok = a1 & a2 & a3;
  endtask

  function automatic logic [7:0] exp_status(input logic t, input logic o, input logic l,
                                            input logic [NSTR-1:0] off);
    int n;
    logic f1, f2;
    n = 0;
    for (int i = 0; i < NSTR; i++) if (off[i]) n++;
    f1 = (n >= 1);
    f2 = (n >= 2);
    return (8'(f2) << 5) | (8'(f1) << 4) | (8'(l) << 3) | (8'(o) << 2) | (8'(t) << 1)
           | 8'(t | o | f1 | f2);
  endfunction

  initial begin
    logic ok;
    logic [7:0] d;
    logic [7:0] v;

    wt(5);
    chk("R3 reset brightness", brightness, 8'hFF);
    chk("R4 reset controls", {5'b0, pwm_md, pwm_sel, bl_on}, 8'h00);
    chk("R1 reset sda released", {7'b0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    wt(10);

    rd_txn(8'h03, d, ok);
    chk("R6 id ack", {7'b0, ok}, 8'h01);
    chk("R6 id value", d, 8'hB0);
    rd_txn(8'h00, d, ok);
    chk("R3 brightness readback default", d, 8'hFF);
    rd_txn(8'h01, d, ok);
    chk("R4 control readback default", d, 8'h00);

    // R2 sweep of brightness values
    for (int k = 0; k < 16; k++) begin
      v = 8'(k * 17 + (k % 3));
      wr_txn(8'h00, v, ok);
      chk("R2 write acks", {7'b0, ok}, 8'h01);
      chk("R2 brightness port", brightness, v);
      rd_txn(8'h00, d, ok);
      chk("R2 brightness readback", d, v);
    end

    // R4 reserved bits
    wr_txn(8'h01, 8'hFD, ok);
    chk("R4 control port fields", {5'b0, pwm_md, pwm_sel, bl_on}, 8'h05);
    rd_txn(8'h01, d, ok);
    chk("R4 control upper bits zero", d, 8'h05);

    // R3 write ignored while PWM selected
    wr_txn(8'h00, 8'h5C, ok);
    wr_txn(8'h01, 8'h02, ok);
    chk("R4 pwm_sel set", {7'b0, pwm_sel}, 8'h01);
    wr_txn(8'h00, 8'h33, ok);
    chk("R3 ignored write acked", {7'b0, ok}, 8'h01);
    chk("R3 brightness held", brightness, 8'h5C);
    rd_txn(8'h00, d, ok);
    chk("R3 brightness readable in pwm mode", d, 8'h5C);
    wr_txn(8'h01, 8'h00, ok);

    // R7 backlight on/off
    wr_txn(8'h01, 8'h01, ok);
    chk("R7 backlight on", {7'b0, bl_on}, 8'h01);
    wr_txn(8'h01, 8'h00, ok);
    chk("R7 backlight off", {7'b0, bl_on}, 8'h00);

    // R5 status sweep
    for (int i = 0; i < 16; i++) begin
      flt_thermal = i[2];
      flt_ocp     = i[3];
      bl_lit      = i[0] ^ i[1];
      case (i % 4)
        0: str_off = 8'h00;
        1: str_off = 8'h20;
        2: str_off = 8'h41;
        default: str_off = 8'hFF;
      endcase
      rd_txn(8'h02, d, ok);
      chk("R5 status byte", d, exp_status(flt_thermal, flt_ocp, bl_lit, str_off));
    end
    flt_thermal = 1'b0; flt_ocp = 1'b0; bl_lit = 1'b0; str_off = '0;

    // R8 high command codes
    wr_txn(8'h07, 8'hA5, ok);
    chk("R8 high cmd write acked", {7'b0, ok}, 8'h01);
    chk("R8 brightness untouched", brightness, 8'h5C);
    chk("R8 control untouched", {5'b0, pwm_md, pwm_sel, bl_on}, 8'h00);
    rd_txn(8'h07, d, ok);
    chk("R8 high cmd read ack", {7'b0, ok}, 8'h01);
    chk("R8 high cmd read zero", d, 8'h00);

    // R1 wrong address
    begin
      logic a;
      oe_seen = 1'b0;
      m_start;
      m_send(8'h5A, a);
      m_send(8'h00, ok);
      m_send(8'h11, ok);
      m_stop;
      chk("R1 wrong address nack", {7'b0, a}, 8'h00);
      chk("R1 sda stays released", {7'b0, oe_seen}, 8'h00);
      chk("R1 no write on wrong address", brightness, 8'h5C);
    end

    // R9 abort by STOP mid data byte
    begin
      logic a;
      m_start;
      m_send(8'h58, a);
      m_send(8'h00, a);
      for (int i = 0; i < 4; i++) m_bit_out(1'b1);
      m_stop;
      chk("R9 stop abort no write", brightness, 8'h5C);
      chk("R9 stop abort releases", {7'b0, sda_oe}, 8'h00);
      m_start;
      m_send(8'h58, a);
      m_send(8'h00, a);
      for (int i = 0; i < 3; i++) m_bit_out(1'b0);
      chk("R9 partial no write", brightness, 8'h5C);
    end
    m_start;
    begin
      logic a1, a2, a3;
      m_send(8'h58, a1);
      m_send(8'h00, a2);
      m_send(8'h44, a3);
      m_stop;
      chk("R9 transfer after restart", brightness, 8'h44);
      chk("R9 restart acks", {5'b0, a1, a2, a3}, 8'h07);
    end

    chk("R10 pull-down begins with SCL low", 8'(oe_high_scl), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule